// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Bank

This block holds the control settings of a down-conversion receiver: the three synthesizer divider counts (main, swallow and reference), an enable for the reference-clock output pin, the choice between the low-pass and band-pass IF filter, a test enable, and the test injection and observation point selects. Software loads these settings over a three-wire bus made of a data line, a bus clock and a latch line. The bus is asynchronous to the system clock. All three lines pass through two-flop synchronizers and are edge-detected in the system clock domain. Each frame is 18 bits long: sixteen payload bits, then two address bits. A rising edge on the latch line writes the payload into one of four registers.

The same three bus pins also act as strap inputs. When the enable input rises after a long enough low period, the static levels on (data, clock, latch) pick one of three preset configurations, and the bank loads it. A low pulse on enable that is too short does not re-initialize the bank, and it keeps its contents. While enable is low the bank is in power save and ignores latch pulses. The test-point selects leave the block one-hot, and they are forced to zero unless the test enable bit is set.

A controller with four states governs the bank. `ST_LOW` counts the cycles during which enable is low. `ST_READY` means enable has been low long enough, and it is also the state entered on reset. `ST_LOAD` is the single cycle in which the preset is applied. `ST_ACTIVE` accepts bus writes. The transitions are:
- `ST_LOW`→`ST_ACTIVE`: enable returns before the count expires.
- `ST_LOW`→`ST_READY`: the count reaches `MIN_LOW_CYC`.
- `ST_READY`→`ST_LOAD`: enable rises.
- `ST_LOAD`→`ST_ACTIVE`: always, after one cycle.
- `ST_ACTIVE`→`ST_LOW`: enable falls.

Top module: `cfgbus_regbank`

## Requirements
- R1: A bit is shifted in on each rising edge of the bus clock. The first bit of a frame is payload bit 0 and the sixteenth is payload bit 15. The seventeenth bit is address bit 0 and the eighteenth is address bit 1. When more than 18 bits arrive before a latch, only the last 18 count.
- R2: A rising edge on the latch line, while in `ST_ACTIVE`, writes the 16-bit payload to the register selected by the address. The other three registers do not change.
- R3: The payload fields are placed as follows:
  - Address 00: the main count is in payload[10:0].
  - Address 01: the reference count is in payload[8:0] and the swallow count is in payload[13:9].
  - Address 10: payload[0] is the reference-clock output enable, payload[1] selects band-pass (1) or low-pass (0), and payload[2] is the test enable.
  - Address 11: the injection code is in payload[2:0] and the observation code is in payload[5:3].
- R4: The injection select `tin_sel_o` decodes the code as follows: 001→bit0 (I-channel first amp input), 010→bit1 (Q-channel first amp input), 101→bit2 (filter input), 110→bit3 (second amp input), 111→bit4 (converter input).
- R5: The observation select `tout_sel_o` decodes the code as follows: 001→bit0 (I mixer output), 010→bit1 (Q mixer output), 101→bit2 (adder output), 110→bit3 (filter output), 111→bit4 (second amp output).
- R6: Both selects are all zero when the test enable is 0, and also for code 000 and for the unused codes 011 and 100.
- R7: On a valid enable rise, the strap levels (data, clock, latch) pick the preset:
  - 100: main 7, swallow 3, reference 4, low-pass.
  - 110: main 22, swallow 17, reference 9, low-pass.
  - 000, and any other value: main 6, swallow 0, reference 3, band-pass.
  In every preset the clock output, the test enable and both codes are 0.
- R8: A preset loads only if enable has been low for at least `MIN_LOW_CYC` synchronized cycles, or if this is the first rise after reset. A shorter low pulse leaves every register as it was.
- R9: Latch pulses that arrive while enable is low have no effect.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Active mode when high, power save when low |
| bus_data_i | input | 1 | Serial data line, also strap bit 2 |
| bus_clk_i | input | 1 | Serial bus clock, also strap bit 1 |
| bus_latch_i | input | 1 | Latch line, also strap bit 0 |
| main_cnt_o | output | 11 | Main divider count |
| swal_cnt_o | output | 5 | Swallow divider count |
| ref_cnt_o | output | 9 | Reference divider count |
| refclk_oe_o | output | 1 | Reference-clock output enable |
| bandpass_o | output | 1 | 1 selects the band-pass filter, 0 the low-pass filter |
| test_en_o | output | 1 | Test I/O enable |
| tin_sel_o | output | 5 | One-hot test injection point |
| tout_sel_o | output | 5 | One-hot test observation point |

## Verification
An internal fault shows up at the ports in one of a few ways:
- A shifter that is off by one bit, or that puts the address in the wrong place, sends a payload to the wrong register or shifts its field. The corrupted count appears on the outputs about three system cycles after the latch edge.
- An error in the controller's low-time counter either loads a preset after a short enable glitch or fails to load one after a long low period. In both cases the divider outputs are wrong a few cycles after enable rises.
- A decode or gating error puts a stray or duplicated bit on a select output as soon as its code register changes.

The directed scenarios write every field, walk all eight codes with test enable both off and on, send an overlong frame, and toggle enable with both short and long low periods.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

    localparam int FRAME_W = 18;
    localparam int PAY_W   = 16;
    localparam int ADDR_W  = FRAME_W - PAY_W;
    localparam int MAIN_W  = 11;
    localparam int SWAL_W  = 5;
    localparam int REF_W   = 9;
    localparam int CODE_W  = 3;
    localparam int NPTS    = 5;

    // Field positions inside the payload
    localparam int SWAL_LSB   = REF_W;
    localparam int CLKOE_BIT  = 0;
    localparam int BPASS_BIT  = 1;
    localparam int TESTEN_BIT = 2;
    localparam int TOUT_LSB   = CODE_W;

    typedef enum logic [1:0] {
        ST_LOW    = 2'd0,
        ST_READY  = 2'd1,
        ST_LOAD   = 2'd2,
        ST_ACTIVE = 2'd3
    } cfg_state_e;

    typedef struct packed {
        logic [MAIN_W-1:0] main_cnt;
        logic [SWAL_W-1:0] swal_cnt;
        logic [REF_W-1:0]  ref_cnt;
        logic              clk_oe;
        logic              bandpass;
        logic              test_en;
        logic [CODE_W-1:0] tin_code;
        logic [CODE_W-1:0] tout_code;
    } cfg_t;

    // Strap order: {data, clock, latch}
    function automatic cfg_t preset_cfg(input logic [2:0] strap);
        cfg_t c;
        c = '0;
        unique case (strap)
            3'b100: begin
                c.main_cnt = MAIN_W'(7);
                c.swal_cnt = SWAL_W'(3);
                c.ref_cnt  = REF_W'(4);
            end
            3'b110: begin
                c.main_cnt = MAIN_W'(22);
                c.swal_cnt = SWAL_W'(17);
                c.ref_cnt  = REF_W'(9);
            end
            default: begin
                c.main_cnt = MAIN_W'(6);
                c.swal_cnt = SWAL_W'(0);
                c.ref_cnt  = REF_W'(3);
                c.bandpass = 1'b1;
            end
        endcase
        return c;
    endfunction

    // Shared point numbering for injection and observation codes
    function automatic logic [NPTS-1:0] point_onehot(input logic [CODE_W-1:0] code);
        logic [NPTS-1:0] v;
        unique case (code)
            3'b001:  v = 5'b00001;
            3'b010:  v = 5'b00010;
            3'b101:  v = 5'b00100;
            3'b110:  v = 5'b01000;
            3'b111:  v = 5'b10000;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfg_bit_sync.sv
module cfg_bit_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] frame_o
);
    logic [W-1:0] sr_q;

    // Newest bit enters at the top; the first bit of a frame ends at bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (shift_i)
            sr_q <= {bit_i, sr_q[W-1:1]};
    end

    assign frame_o = sr_q;
endmodule

// File: rtl/cfg_ctrl_fsm.sv
module cfg_ctrl_fsm
    import cfgbus_pkg::*;
#(
    parameter int MIN_LOW_CYC = 2_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       lat_rise_i,
    output cfg_state_e st_o,
    output logic       load_o,
    output logic       commit_o
);
    localparam int CW = $clog2(MIN_LOW_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW_CYC - 1);

    cfg_state_e st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_READY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == ST_LOW && st_d == ST_LOW) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOW: begin
                if (en_i)
                    st_d = ST_ACTIVE;
                else if (cnt_q == LAST)
                    st_d = ST_READY;
            end
            ST_READY:  if (en_i) st_d = ST_LOAD;
            ST_LOAD:   st_d = ST_ACTIVE;
            ST_ACTIVE: if (!en_i) st_d = ST_LOW;
            default:   st_d = ST_READY;
        endcase
    end

    always_comb begin
        load_o   = 1'b0;
        commit_o = 1'b0;
        unique case (st_q)
            ST_LOAD:   load_o   = 1'b1;
            ST_ACTIVE: commit_o = lat_rise_i;
            default: ;
        endcase
    end

    assign st_o = st_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfgbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_cap_i,
    input  logic [2:0]         strap_i,
    input  logic               load_i,
    input  logic               commit_i,
    input  logic [FRAME_W-1:0] frame_i,
    output cfg_t               cfg_o
);
    cfg_t                 cfg_q;
    logic [2:0]           strap_q;
    logic [PAY_W-1:0]     pay;
    logic [ADDR_W-1:0]    addr;

    assign pay  = frame_i[PAY_W-1:0];
    assign addr = frame_i[FRAME_W-1:PAY_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            strap_q <= '0;
        else if (strap_cap_i)
            strap_q <= strap_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load_i) begin
            cfg_q <= preset_cfg(strap_q);
        end else if (commit_i) begin
            unique case (addr)
                2'b00: cfg_q.main_cnt <= pay[MAIN_W-1:0];
                2'b01: begin
                    cfg_q.ref_cnt  <= pay[REF_W-1:0];
                    cfg_q.swal_cnt <= pay[SWAL_LSB +: SWAL_W];
                end
                2'b10: begin
                    cfg_q.clk_oe   <= pay[CLKOE_BIT];
                    cfg_q.bandpass <= pay[BPASS_BIT];
                    cfg_q.test_en  <= pay[TESTEN_BIT];
                end
                2'b11: begin
                    cfg_q.tin_code  <= pay[CODE_W-1:0];
                    cfg_q.tout_code <= pay[TOUT_LSB +: CODE_W];
                end
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/cfgbus_regbank.sv
module cfgbus_regbank
    import cfgbus_pkg::*;
#(
    parameter int MIN_LOW_CYC = 2_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              bus_data_i,
    input  logic              bus_clk_i,
    input  logic              bus_latch_i,
    output logic [MAIN_W-1:0] main_cnt_o,
    output logic [SWAL_W-1:0] swal_cnt_o,
    output logic [REF_W-1:0]  ref_cnt_o,
    output logic              refclk_oe_o,
    output logic              bandpass_o,
    output logic              test_en_o,
    output logic [NPTS-1:0]   tin_sel_o,
    output logic [NPTS-1:0]   tout_sel_o
);
    logic [3:0]         pins_s;
    logic               en_s, dat_s, bclk_s, lat_s;
    logic               bclk_q, lat_q;
    logic               bclk_rise, lat_rise;
    logic [FRAME_W-1:0] frame;
    cfg_state_e         st;
    logic               load, commit;
    cfg_t               cfg;

    cfg_bit_sync #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({enable_i, bus_data_i, bus_clk_i, bus_latch_i}),
        .q_o   (pins_s)
    );

    assign {en_s, dat_s, bclk_s, lat_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            lat_q  <= 1'b0;
        end else begin
            bclk_q <= bclk_s;
            lat_q  <= lat_s;
        end
    end

    assign bclk_rise = bclk_s & ~bclk_q;
    assign lat_rise  = lat_s & ~lat_q;

    cfg_frame_shifter #(.W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (bclk_rise),
        .bit_i   (dat_s),
        .frame_o (frame)
    );

    cfg_ctrl_fsm #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_s),
        .lat_rise_i (lat_rise),
        .st_o       (st),
        .load_o     (load),
        .commit_o   (commit)
    );

    cfg_reg_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_cap_i (st == ST_READY && en_s),
        .strap_i     ({dat_s, bclk_s, lat_s}),
        .load_i      (load),
        .commit_i    (commit),
        .frame_i     (frame),
        .cfg_o       (cfg)
    );

    assign main_cnt_o  = cfg.main_cnt;
    assign swal_cnt_o  = cfg.swal_cnt;
    assign ref_cnt_o   = cfg.ref_cnt;
    assign refclk_oe_o = cfg.clk_oe;
    assign bandpass_o  = cfg.bandpass;
    assign test_en_o   = cfg.test_en;
    assign tin_sel_o   = cfg.test_en ? point_onehot(cfg.tin_code)  : '0;
    assign tout_sel_o  = cfg.test_en ? point_onehot(cfg.tout_code) : '0;
endmodule

// File: rtl/cfgbus_regbank_chk.sv
module cfgbus_regbank_chk
    import cfgbus_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        st_v,
    input logic              commit_v,
    input logic [MAIN_W-1:0] main_cnt_o,
    input logic [REF_W-1:0]  ref_cnt_o,
    input logic              test_en_o,
    input logic [NPTS-1:0]   tin_sel_o,
    input logic [NPTS-1:0]   tout_sel_o
);
    // R4
    tin_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tin_sel_o));

    // R5
    tout_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tout_sel_o));

    // R6
    test_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en_o |-> (tin_sel_o == '0 && tout_sel_o == '0));

    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_v == ST_LOW || st_v == ST_READY) |=> ($stable(main_cnt_o) && $stable(ref_cnt_o)));

    // R8
    load_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_v == ST_LOAD) |=> (st_v == ST_ACTIVE));

    // R2
    commit_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_v |-> (st_v == ST_ACTIVE));
endmodule

bind cfgbus_regbank cfgbus_regbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_v       (st),
    .commit_v   (commit),
    .main_cnt_o (main_cnt_o),
    .ref_cnt_o  (ref_cnt_o),
    .test_en_o  (test_en_o),
    .tin_sel_o  (tin_sel_o),
    .tout_sel_o (tout_sel_o)
);

// File: tb/tb_cfgbus_regbank.sv
module tb_cfgbus_regbank;
    localparam int MINLOW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, bd = 1'b0, bc = 1'b0, bl = 1'b0;
    logic [10:0] main_cnt;
    logic [4:0]  swal_cnt;
    logic [8:0]  ref_cnt;
    logic        clkoe, bpass, testen;
    logic [4:0]  tin, tout;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // expected model
    logic [10:0] e_main;
    logic [4:0]  e_swal;
    logic [8:0]  e_ref;
    logic        e_oe, e_bp, e_te;
    logic [2:0]  e_tin, e_tout;

    always #2.5 clk = ~clk;

    cfgbus_regbank #(.MIN_LOW_CYC(MINLOW)) dut (
        .clk(clk), .rst_n(rst_n), .enable_i(en),
        .bus_data_i(bd), .bus_clk_i(bc), .bus_latch_i(bl),
        .main_cnt_o(main_cnt), .swal_cnt_o(swal_cnt), .ref_cnt_o(ref_cnt),
        .refclk_oe_o(clkoe), .bandpass_o(bpass), .test_en_o(testen),
        .tin_sel_o(tin), .tout_sel_o(tout)
    );

    function automatic logic [4:0] exp_sel(input logic te, input logic [2:0] c);
        if (!te) return 5'd0;
        case (c)
            3'b001: return 5'b00001;
            3'b010: return 5'b00010;
            3'b101: return 5'b00100;
            3'b110: return 5'b01000;
            3'b111: return 5'b10000;
            default: return 5'd0;
        endcase
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [40:0] act, exp;
        act = {main_cnt, swal_cnt, ref_cnt, clkoe, bpass, testen, tin, tout};
        exp = {e_main, e_swal, e_ref, e_oe, e_bp, e_te,
               exp_sel(e_te, e_tin), exp_sel(e_te, e_tout)};
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            bd = v[i];
            wait_cyc(4);
            bc = 1'b1;
            wait_cyc(4);
            bc = 1'b0;
            wait_cyc(4);
        end
    endtask

    task automatic pulse_latch();
        bl = 1'b1;
        wait_cyc(4);
        bl = 1'b0;
        wait_cyc(8);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] p);
        send_bits({14'd0, a, p}, 18);
        bd = 1'b0;
        pulse_latch();
        if (en) begin
            case (a)
                2'b00: e_main = p[10:0];
                2'b01: begin e_ref = p[8:0]; e_swal = p[13:9]; end
                2'b10: begin e_oe = p[0]; e_bp = p[1]; e_te = p[2]; end
                default: begin e_tin = p[2:0]; e_tout = p[5:3]; end
            endcase
        end
    endtask

    task automatic set_preset(input logic [2:0] s);
        e_oe = 0; e_te = 0; e_tin = 0; e_tout = 0;
        case (s)
            3'b100: begin e_main = 7;  e_swal = 3;  e_ref = 4; e_bp = 0; end
            3'b110: begin e_main = 22; e_swal = 17; e_ref = 9; e_bp = 0; end
            default: begin e_main = 6; e_swal = 0;  e_ref = 3; e_bp = 1; end
        endcase
    endtask

    // Long low, straps applied, enable rise
    task automatic reinit(input logic [2:0] s);
        en = 1'b0;
        wait_cyc(MINLOW + 20);
        {bd, bc, bl} = s;
        wait_cyc(6);
        en = 1'b1;
        wait_cyc(10);
        {bd, bc, bl} = 3'b000;
        wait_cyc(6);
        set_preset(s);
    endtask

    task automatic t_reset();
        e_main = 0; e_swal = 0; e_ref = 0; e_oe = 0; e_bp = 0;
        e_te = 0; e_tin = 0; e_tout = 0;
        check_all("R10 reset");
    endtask

    task automatic t_power_on();
        en = 1'b1;
        wait_cyc(10);
        set_preset(3'b000);
        check_all("R7 power-on preset 000");
    endtask

    task automatic t_fields();
        write_reg(2'b00, 16'hFDA3);
        check_all("R1 R2 R3 main count");
        write_reg(2'b01, {2'b11, 5'h15, 9'h1A5});
        check_all("R3 swallow/reference");
        write_reg(2'b10, 16'h0003);
        check_all("R3 control bits");
    endtask

    task automatic t_test_gate();
        write_reg(2'b11, {10'd0, 3'b110, 3'b001});
        check_all("R6 selects gated off");
        write_reg(2'b10, 16'h0004);
        check_all("R4 R5 test enabled");
    endtask

    task automatic t_codes();
        for (int c = 0; c < 8; c++) begin
            write_reg(2'b11, {10'd0, 3'(7 - c), 3'(c)});
            check_all("R4 R5 R6 code walk");
        end
    endtask

    task automatic t_overlong();
        send_bits(32'h0000001F, 5);
        write_reg(2'b00, 16'h0234);
        check_all("R1 overlong frame");
    endtask

    task automatic t_short_low();
        en = 1'b0;
        wait_cyc(10);
        en = 1'b1;
        wait_cyc(10);
        check_all("R8 short low keeps registers");
    endtask

    task automatic t_sleep_write();
        en = 1'b0;
        wait_cyc(4);
        write_reg(2'b00, 16'h0111);
        check_all("R9 latch ignored while low");
        en = 1'b1;
        wait_cyc(10);
        set_preset(3'b000);
        check_all("R8 long low reloads preset");
    endtask

    task automatic t_presets();
        reinit(3'b100);
        check_all("R7 preset 100");
        reinit(3'b110);
        check_all("R7 preset 110");
        reinit(3'b011);
        check_all("R7 other strap uses 000 preset");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_power_on();
        t_fields();
        t_test_gate();
        t_codes();
        t_overlong();
        t_short_low();
        t_sleep_write();
        t_presets();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule